// File: doc/BRIEF.md
# Interrupt Controller Initialization and Clear-Notification Core

This block is an eight-input priority interrupt controller core whose main job is its setup path. A write to the command address with data bit 4 set starts the setup sequence. That write empties the in-service register and the mask register. It drops pending requests on edge-sensed inputs but keeps those on level-sensed inputs. Every pin whose in-service bit or edge request was discarded produces one clear notification on a separate ready/valid stream.

The interrupt output stays low for the whole setup sequence. After the last setup word, the controller works in the usual way. The lowest-numbered pending, unmasked request raises the output when it has higher priority than every in-service pin. An acknowledge input moves that request into service, and a non-specific end-of-interrupt command retires the highest-priority in-service pin.

Top module: `pic_init_ctrl`

## Requirements
- R1: A write with `wr_addr`=0 and `wr_data[4]`=1 starts setup. `int_out` stays low from that write until the last required setup word has been written.
- R2: The setup-start write clears the request bits of edge-sensed inputs (`trig_level` bit = 0). Level-sensed request bits keep following their input lines.
- R3: The setup-start write clears every in-service bit and every mask bit.
- R4: At the setup-start write, the set of pins to notify is the old in-service bits OR the old edge-sensed request bits. The block emits exactly one notification per pin in that set, in ascending pin order.
- R5: The notified pin number `eoi_pin` is {`sec_sel` captured at the setup-start write, 3-bit local pin}. When `sec_sel` was 1, this equals the local pin plus 8.
- R6: Setup words after the start word go to `wr_addr`=1. The first one sets `vec_base` to `wr_data[7:3]`. A cascade word follows only when start-word bit 1 is 0. A mode word follows only when start-word bit 0 is 1.
- R7: A level-sensed line held high through setup raises `int_out` as soon as setup ends, with no new rising edge.
- R8: Outside setup, `int_out` is high when the lowest pending unmasked pin is lower than the lowest in-service pin (or no pin is in service). A pulse on `int_ack` moves that pin into service.
- R9: A command write of 8'h20 (`wr_addr`=0, bits 7:5 = 001, bits 4:3 = 00) clears the lowest in-service bit.
- R10: While notifications are outstanding, a setup-start write raises `wr_hold` and has no effect.
- R11: Outside setup, a write with `wr_addr`=1 loads the mask register. A masked pin never raises `int_out`.
- R12: While `eoi_valid` is high and `eoi_ready` is low, `eoi_pin` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = command address, 1 = data address |
| wr_data | input | 8 | Write data |
| sec_sel | input | 1 | Selects the secondary controller; captured at setup start |
| wr_hold | output | 1 | Setup-start write refused because notifications are pending |
| irq_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-pin sense select: 1 = level, 0 = edge |
| int_ack | input | 1 | Acknowledge; moves the winning request into service |
| int_out | output | 1 | Interrupt output |
| vec_base | output | 5 | Vector base from the first setup data word |
| eoi_valid | output | 1 | A clear notification is available |
| eoi_ready | input | 1 | Consumer accepts the notification |
| eoi_pin | output | 4 | Global pin number of the notification |

## Verification
The bench places one pin in service, a lower-priority level pin and an edge pin behind it, and then starts setup from the secondary side with the consumer stalled.

Each fault shows at the ports:
- A design that kept the in-service bit, or restored the old mask, would leave the held level pin silent after setup.
- A design that kept the edge request would still assert the output once the level line drops.
- A design that lost a notification, repeated one, or misordered them would show the wrong pin sequence or a missing offset of 8.

Further checks cover each word-count variant of the setup sequence, and a second setup-start write refused while the stream still drains.

// File: rtl/pic_init_ctrl.sv
module pic_init_ctrl #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            sec_sel,
  output logic            wr_hold,
  input  logic [NPIN-1:0] irq_in,
  input  logic [NPIN-1:0] trig_level,
  input  logic            int_ack,
  output logic            int_out,
  output logic [4:0]      vec_base,
  output logic            eoi_valid,
  input  logic            eoi_ready,
  output logic [3:0]      eoi_pin
);
  localparam int IW = $clog2(NPIN);

  logic [NPIN-1:0] irr, isr, imr, pend, irq_q;
  logic [3:0]      init_st;
  logic [1:0]      step;
  logic            sec_r;

  function automatic logic [IW-1:0] low_idx(input logic [NPIN-1:0] v);
    low_idx = '0;
    for (int i = NPIN-1; i >= 0; i--)
      if (v[i]) low_idx = IW'(i);
  endfunction

  wire cmd_wr   = wr_en & ~wr_addr;
  wire dat_wr   = wr_en &  wr_addr;
  wire icw1_req = cmd_wr & wr_data[4];
  assign wr_hold = icw1_req & (|pend);
  wire icw1_go  = icw1_req & ~wr_hold;
  wire ns_eoi   = cmd_wr & ~wr_data[4] & ~wr_data[3] & (wr_data[7:5] == 3'b001);
  wire sngl     = init_st[3];
  wire need4    = init_st[2];

  wire [NPIN-1:0] req     = irr & ~imr;
  wire [NPIN-1:0] req_low = req & (~req + 1'b1);
  wire [NPIN-1:0] isr_low = isr & (~isr + 1'b1);
  wire [NPIN-1:0] rise    = irq_in & ~irq_q;

  assign int_out = (init_st == 4'd0) & (|req) & ((isr == '0) | (req_low < isr_low));
  wire [NPIN-1:0] ack_bit = (int_ack & int_out) ? req_low : '0;

  assign eoi_valid = |pend;
  assign eoi_pin   = {sec_r, low_idx(pend)};
  wire eoi_fire    = eoi_valid & eoi_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr <= '0; isr <= '0; imr <= '0; pend <= '0; irq_q <= '0;
      init_st <= '0; step <= '0; sec_r <= 1'b0; vec_base <= '0;
    end else begin
      irq_q <= irq_in;
      if (icw1_go) begin
        irr     <= irq_in & trig_level;
        isr     <= '0;
        imr     <= '0;
        pend    <= isr | (irr & ~trig_level);
        sec_r   <= sec_sel;
        init_st <= {wr_data[1:0], 2'b01};
        step    <= 2'd0;
      end else begin
        irr <= (irq_in & trig_level) | ((irr | rise) & ~trig_level & ~ack_bit);
        isr <= (isr | ack_bit) & ~(ns_eoi ? isr_low : '0);
        if (eoi_fire) pend <= pend & (pend - 1'b1);
        if (dat_wr) begin
          if (init_st[0]) begin
            case (step)
              2'd0: begin
                vec_base <= wr_data[7:3];
                if (!sngl)     step <= 2'd1;
                else if (need4) step <= 2'd2;
                else           init_st <= '0;
              end
              2'd1: if (need4) step <= 2'd2; else init_st <= '0;
              default: init_st <= '0;
            endcase
          end else begin
            imr <= wr_data[NPIN-1:0];
          end
        end
      end
    end
  end

  a_r3_icw1_clears: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_go |=> (isr == '0) && (imr == '0) && init_st[0]);
  a_r10_hold_needs_stream: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold |-> eoi_valid);
  a_r4_one_per_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !icw1_go) |=> $countones(pend) == $countones($past(pend)) - 1);
  a_r12_pin_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !eoi_ready && !icw1_go) |=> $stable(eoi_pin));
  a_r8_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_out && !icw1_go) |=> isr != '0);
endmodule

// File: tb/tb_pic_init_ctrl.sv
module tb_pic_init_ctrl;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  // each entry: {line pattern, mask, expected int_out} with all pins level-sensed
  localparam logic [16:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0},
    {8'h04, 8'h00, 1'b1},
    {8'h04, 8'h04, 1'b0},
    {8'h84, 8'h04, 1'b1},
    {8'hFF, 8'hFF, 1'b0},
    {8'h10, 8'hEF, 1'b1}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, wr_addr = 0, sec_sel = 0, int_ack = 0, eoi_ready = 0;
  logic [7:0] wr_data = 0, irq_in = 0, trig_level = 0;
  logic wr_hold, int_out, eoi_valid;
  logic [4:0] vec_base;
  logic [3:0] eoi_pin;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pic_init_ctrl dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .sec_sel, .wr_hold,
    .irq_in, .trig_level, .int_ack, .int_out, .vec_base, .eoi_valid, .eoi_ready, .eoi_pin);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ack();
    @(negedge clk); int_ack = 1;
    @(negedge clk); int_ack = 0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset int_out", int_out, 0);
    chk("R4 reset eoi_valid", eoi_valid, 0);

    // Table: all level-sensed, start word 8'h12 (single, no mode word)
    trig_level = 8'hFF;
    wr(0, 8'h12);
    chk("R1 int low in setup", int_out, 0);
    wr(1, 8'h40);
    chk("R6 vec_base", vec_base, 8);
    for (int k = 0; k < NV; k++) begin
      irq_in = VEC[k][16:9];
      wr(1, VEC[k][8:1]);
      wait_n(1);
      chk($sformatf("R11 table entry %0d", k), int_out, VEC[k][0]);
    end

    // Directed: pins 0,3 level; pins 1,5 edge
    irq_in = 0; wr(1, 8'h00);
    trig_level = 8'b0000_1001;
    wr(0, 8'h13);
    wr(1, 8'h20);
    chk("R6 mode word still pending", int_out, 0);
    @(negedge clk); irq_in = 8'b0010_1010;
    wait_n(1);
    chk("R1 int low before last word", int_out, 0);
    wr(1, 8'h01);
    chk("R8 int after setup", int_out, 1);
    ack();
    chk("R8 lower pins blocked by service", int_out, 0);
    wr(1, 8'h08);
    // setup from secondary side while consumer stalled
    @(negedge clk); sec_sel = 1;
    wr(0, 8'h11);
    sec_sel = 0;
    chk("R4 stream valid", eoi_valid, 1);
    chk("R5 first pin", eoi_pin, 9);
    chk("R1 level pin silent during setup", int_out, 0);
    wait_n(2);
    chk("R12 pin held", eoi_pin, 9);
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = 8'h13;
    #1 chk("R10 hold", wr_hold, 1);
    @(negedge clk); wr_en = 0;
    @(negedge clk); eoi_ready = 1;
    @(negedge clk); eoi_ready = 0;
    chk("R4 second pin", eoi_pin, 13);
    @(negedge clk); eoi_ready = 1;
    @(negedge clk); eoi_ready = 0;
    chk("R4 stream empty", eoi_valid, 0);
    wr(1, 8'hA8);
    chk("R6 sec vec_base", vec_base, 21);
    wr(1, 8'h02);
    chk("R6 cascade word keeps setup", int_out, 0);
    wr(1, 8'h01);
    chk("R7 level pin rises after setup", int_out, 1);
    chk("R3 mask and service cleared", int_out, 1);
    chk("R10 refused write ignored", eoi_valid, 0);
    ack();
    chk("R8 own service blocks", int_out, 0);
    wr(0, 8'h20);
    chk("R9 eoi reopens level pin", int_out, 1);
    ack();
    @(negedge clk); irq_in = 8'b0000_0000;
    wr(0, 8'h20);
    wait_n(1);
    chk("R2 edge request dropped", int_out, 0);
    @(negedge clk); irq_in = 8'b0000_0001;
    wait_n(1);
    chk("R2 level request follows line", int_out, 1);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule